// File: doc/BRIEF.md
# Byte-wide SPI controller with sticky status flags

This block is a serial peripheral interface engine that works either as the clock-driving master or as a clocked slave. It exchanges one byte per transfer, most significant bit first, in clock mode 0: the clock idles low, data is sampled on the rising edge and changed on the falling edge. A processor reaches it through three paths. The first is a single 8-bit control and status register. The second is a data write path into a one-byte transmit buffer that feeds the shift register. The third is a data read path that takes bytes from a receive buffer, which is loaded when a transfer completes.

Four sticky flags report events: transfer complete, write collision, mode fault and slave receive overrun. Software clears each one by writing 0 to it. Any flag that is set holds a single level interrupt high. A two-bit select-mode field decides how the slave-select pin is used: it is ignored (3-wire), it is always an input, or it is an output driven from the low bit of that field. Master mode is enabled by a separate configuration write. A mode fault drops the block back to slave operation.

The master clock runs at a fixed fraction of the system clock, set by a parameter. Slave inputs pass through two-stage synchronizers before any edge is detected.

Top module: `spi_ctrl`

## Requirements
- R1: After reset the register reads 0x06, the interrupt is low, master mode is off and the receive byte reads 0x00. Register layout, MSB to LSB: done[7], collision[6], fault[5], overrun[4], select mode[3:2], transmit empty[1] (read-only), enable[0].
- R2: In master mode, a byte in the transmit buffer is shifted out on mosi_o MSB first. Each bit is stable at the rising edge of sck_o. The byte gathered from miso_i goes into the receive buffer, the done flag sets, and sck_o stays low between transfers.
- R3: Transmit empty reads 0 in the cycle after a data write. It returns to 1 in the cycle after the byte moves into the shift register.
- R4: A data write while a transfer is in progress sets the collision flag. The written byte is dropped: the ongoing transfer completes with its original byte and no further transfer starts.
- R5: With enable 1, master mode on, select mode 01 and the synchronized ss_n_i low, the fault flag sets and master mode clears in the next cycle. In select mode 00, a low ss_n_i causes no fault.
- R6: In slave mode the block samples mosi_i on rising sck_i and shifts on falling sck_i. It presents its loaded transmit byte on miso_o MSB first, and after eight bits it stores the received byte and sets done.
- R7: If a slave transfer completes while the receive buffer holds an unread byte, the overrun flag sets and the buffer keeps the old byte. With the buffer read first, the new byte is stored and no overrun occurs.
- R8: Select mode 1x drives ss_n_o equal to mode bit 0 with ss_n_oe_o high (when enabled). Modes 00 and 01 leave ss_n_oe_o low.
- R9: In slave mode with select mode 01, a high ss_n_i makes the block ignore sck_i and hold miso_oe_o low. In select mode 00 the slave is always selected.
- R10: A register write of 0 to a flag bit clears that flag and a write of 1 leaves it unchanged. A hardware set in the same cycle as a clear wins.
- R11: While enable is 0 no transfer starts, sck_o stays low and a written byte stays in the transmit buffer.
- R12: irq_o is high exactly when at least one of the four flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Control/status register write strobe |
| reg_wdata_i | input | 8 | Control/status write data |
| reg_rdata_o | output | 8 | Control/status read value |
| cfg_wr_i | input | 1 | Master-enable write strobe |
| cfg_master_i | input | 1 | Master-enable write value |
| master_o | output | 1 | Current master-enable state |
| data_wr_i | input | 1 | Transmit buffer write strobe |
| data_wdata_i | input | DATA_W | Transmit byte |
| data_rd_i | input | 1 | Receive buffer read strobe |
| rx_data_o | output | DATA_W | Receive buffer contents |
| irq_o | output | 1 | Interrupt, OR of the flags |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Serial data in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| mosi_oe_o | output | 1 | Master data output enable |
| miso_i | input | 1 | Serial data in (master) |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe_o | output | 1 | Slave data output enable |
| ss_n_i | input | 1 | Slave-select input |
| ss_n_o | output | 1 | Slave-select output level |
| ss_n_oe_o | output | 1 | Slave-select output enable |

## Verification
A wrong bit counter or sampling phase shows up at once as a wrong received byte or a wrong MOSI bit order. It also moves the done flag away from the end of the eighth bit. A flag register that loses state or fails to clear shows in the next register read and on irq_o in the same cycle. A transmit-buffer handshake fault shows as a stuck transmit-empty bit one cycle after a write. It can also show as an extra transfer that sets done again within one byte time. Mode-fault and slave-select errors show within three cycles of an ss_n_i change, through master_o and the output enables.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;
  localparam int unsigned CSR_W = 8;
  localparam int unsigned B_DONE = 7;
  localparam int unsigned B_WCOL = 6;
  localparam int unsigned B_MODF = 5;
  localparam int unsigned B_OVR  = 4;
  localparam int unsigned B_MHI  = 3;
  localparam int unsigned B_MLO  = 2;
  localparam int unsigned B_TXE  = 1;
  localparam int unsigned B_EN   = 0;
  localparam int unsigned N_FLAGS = 4;

  typedef enum logic [1:0] {
    SS_NONE   = 2'b00,
    SS_INPUT  = 2'b01,
    SS_OUT_LO = 2'b10,
    SS_OUT_HI = 2'b11
  } ss_mode_e;

  localparam ss_mode_e SS_RESET = SS_INPUT;
endpackage

// File: rtl/spi_ctrl_sync.sv
module spi_ctrl_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_ctrl_clkgen.sv
module spi_ctrl_clkgen #(
  parameter int unsigned CLK_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  if (CLK_DIV <= 1) begin : g_full
    assign tick_o = run_i;
  end else begin : g_div
    localparam int unsigned CW = $clog2(CLK_DIV);
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cnt_q <= '0;
      else if (!run_i)       cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = run_i && (cnt_q == LAST);
  end
endmodule

// File: rtl/spi_ctrl_shift.sv
module spi_ctrl_shift #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CLK_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              master_i,
  input  logic              abort_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_take_o,
  input  logic              miso_i,
  input  logic              sel_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              mosi_i,
  output logic              sck_o,
  output logic              sd_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int unsigned HW = $clog2(2 * DATA_W);
  localparam logic [HW-1:0] M_LAST = HW'(2 * DATA_W - 1);
  localparam logic [HW-1:0] S_LAST = HW'(DATA_W - 1);

  logic [DATA_W-1:0] shift_q;
  logic [HW-1:0]     cnt_q;
  logic              samp_q, busy_q, done_q, tick;

  spi_ctrl_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q && master_i && !abort_i),
    .tick_o (tick)
  );

  assign tx_take_o = en_i && !abort_i && !busy_q && tx_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      cnt_q   <= '0;
      samp_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i || !en_i) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (master_i) begin
        if (tx_take_o) begin
          shift_q <= tx_data_i;
          cnt_q   <= '0;
          busy_q  <= 1'b1;
        end else if (busy_q && tick) begin
          // even half ends on a rising edge, odd half on a falling edge
          if (!cnt_q[0]) samp_q <= miso_i;
          else           shift_q <= {shift_q[DATA_W-2:0], samp_q};
          if (cnt_q == M_LAST) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end else begin
        if (tx_take_o) shift_q <= tx_data_i;
        if (!sel_i) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          if (sck_rise_i) begin
            samp_q <= mosi_i;
            busy_q <= 1'b1;
          end
          if (sck_fall_i && busy_q) begin
            shift_q <= {shift_q[DATA_W-2:0], samp_q};
            if (cnt_q == S_LAST) begin
              busy_q <= 1'b0;
              cnt_q  <= '0;
              done_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
      end
    end
  end

  assign sck_o  = busy_q && master_i && cnt_q[0];
  assign sd_o   = shift_q[DATA_W-1];
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = shift_q;
endmodule

// File: rtl/spi_ctrl_csr.sv
module spi_ctrl_csr
  import spi_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [CSR_W-1:0]  reg_wdata_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_master_i,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] data_wdata_i,
  input  logic              data_rd_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              tx_take_i,
  input  logic [DATA_W-1:0] rx_shift_i,
  input  logic              ss_s_i,
  output logic [CSR_W-1:0]  reg_rdata_o,
  output logic              en_o,
  output ss_mode_e          mode_o,
  output logic              master_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              modf_evt_o,
  output logic              irq_o
);
  logic [N_FLAGS-1:0] flag_q, flag_set, flag_clr;
  logic               en_q, master_q, tx_full_q, rx_full_q, ovr_evt, rx_load;
  ss_mode_e           mode_q;
  logic [DATA_W-1:0]  txbuf_q, rxbuf_q;
  logic               unused_txe_wr;

  assign unused_txe_wr = reg_wdata_i[B_TXE];

  assign modf_evt_o = en_q && master_q && (mode_q == SS_INPUT) && !ss_s_i;
  assign ovr_evt    = done_i && !master_q && rx_full_q && !data_rd_i;
  assign rx_load    = done_i && !ovr_evt;

  // flag order: done, collision, fault, overrun
  assign flag_set = {done_i, data_wr_i && busy_i, modf_evt_o, ovr_evt};
  assign flag_clr = {N_FLAGS{reg_wr_i}} & ~reg_wdata_i[B_DONE:B_OVR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q    <= '0;
      en_q      <= 1'b0;
      mode_q    <= SS_RESET;
      master_q  <= 1'b0;
      tx_full_q <= 1'b0;
      txbuf_q   <= '0;
      rx_full_q <= 1'b0;
      rxbuf_q   <= '0;
    end else begin
      flag_q <= flag_set | (flag_q & ~flag_clr);
      if (reg_wr_i) begin
        en_q   <= reg_wdata_i[B_EN];
        mode_q <= ss_mode_e'(reg_wdata_i[B_MHI:B_MLO]);
      end
      if (modf_evt_o)    master_q <= 1'b0;
      else if (cfg_wr_i) master_q <= cfg_master_i;
      if (data_wr_i && !busy_i) begin
        txbuf_q   <= data_wdata_i;
        tx_full_q <= 1'b1;
      end else if (tx_take_i) begin
        tx_full_q <= 1'b0;
      end
      if (rx_load) begin
        rxbuf_q   <= rx_shift_i;
        rx_full_q <= 1'b1;
      end else if (data_rd_i) begin
        rx_full_q <= 1'b0;
      end
    end
  end

  assign reg_rdata_o = {flag_q, mode_q, ~tx_full_q, en_q};
  assign en_o        = en_q;
  assign mode_o      = mode_q;
  assign master_o    = master_q;
  assign tx_valid_o  = tx_full_q;
  assign tx_data_o   = txbuf_q;
  assign rx_data_o   = rxbuf_q;
  assign irq_o       = |flag_q;
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CLK_DIV = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              cfg_wr_i,
  input  logic              cfg_master_i,
  output logic              master_o,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] data_wdata_i,
  input  logic              data_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              irq_o,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              ss_n_i,
  output logic              ss_n_o,
  output logic              ss_n_oe_o
);
  logic              en, master, modf_evt, busy, done, tx_valid, tx_take;
  logic              sck_s, mosi_s, ss_s, sck_prev_q, sel, sd;
  logic [DATA_W-1:0] tx_data, rx_shift;
  ss_mode_e          mode;

  spi_ctrl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sck_i, mosi_i, ss_n_i}),
    .q_o    ({sck_s, mosi_s, ss_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_prev_q <= 1'b0;
    else         sck_prev_q <= sck_s;
  end

  assign sel = en && !master && ((mode == SS_INPUT) ? !ss_s : 1'b1);

  spi_ctrl_csr #(.DATA_W(DATA_W)) u_csr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_wr_i     (reg_wr_i),
    .reg_wdata_i  (reg_wdata_i),
    .cfg_wr_i     (cfg_wr_i),
    .cfg_master_i (cfg_master_i),
    .data_wr_i    (data_wr_i),
    .data_wdata_i (data_wdata_i),
    .data_rd_i    (data_rd_i),
    .busy_i       (busy),
    .done_i       (done),
    .tx_take_i    (tx_take),
    .rx_shift_i   (rx_shift),
    .ss_s_i       (ss_s),
    .reg_rdata_o  (reg_rdata_o),
    .en_o         (en),
    .mode_o       (mode),
    .master_o     (master),
    .tx_valid_o   (tx_valid),
    .tx_data_o    (tx_data),
    .rx_data_o    (rx_data_o),
    .modf_evt_o   (modf_evt),
    .irq_o        (irq_o)
  );

  spi_ctrl_shift #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .master_i   (master),
    .abort_i    (modf_evt || cfg_wr_i),
    .tx_valid_i (tx_valid),
    .tx_data_i  (tx_data),
    .tx_take_o  (tx_take),
    .miso_i     (miso_i),
    .sel_i      (sel),
    .sck_rise_i (sck_s && !sck_prev_q),
    .sck_fall_i (!sck_s && sck_prev_q),
    .mosi_i     (mosi_s),
    .sck_o      (sck_o),
    .sd_o       (sd),
    .busy_o     (busy),
    .done_o     (done),
    .rx_o       (rx_shift)
  );

  assign master_o  = master;
  assign sck_oe_o  = en && master;
  assign mosi_o    = sd;
  assign mosi_oe_o = en && master;
  assign miso_o    = sd;
  assign miso_oe_o = sel;
  assign ss_n_o    = mode[1] ? mode[0] : 1'b1;
  assign ss_n_oe_o = en && mode[1];
endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       data_wr_i,
  input logic       clr_done_i,
  input logic [7:0] reg_rdata_o,
  input logic       irq_o,
  input logic       master_o,
  input logic       sck_o,
  input logic       busy,
  input logic       done,
  input logic       modf_evt
);
  a_r4_wcol_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_i && busy |=> reg_rdata_o[6]);

  a_r5_fault_drops_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
    modf_evt |=> reg_rdata_o[5] && !master_o);

  a_r10_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[7] && !clr_done_i |=> reg_rdata_o[7]);

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> reg_rdata_o[7]);

  a_r3_load_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) && master_o && !$past(data_wr_i) |-> reg_rdata_o[1]);

  a_r2_sck_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !sck_o);

  a_r12_irq_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (reg_rdata_o[7:4] != 4'h0));
endmodule

bind spi_ctrl spi_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .data_wr_i   (data_wr_i),
  .clr_done_i  (reg_wr_i && !reg_wdata_i[7]),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .master_o    (master_o),
  .sck_o       (sck_o),
  .busy        (busy),
  .done        (done),
  .modf_evt    (modf_evt)
);

// File: tb/spi_ctrl_tb.sv
`timescale 1ns/1ps
module spi_ctrl_tb;
  localparam int unsigned HALF = 6;
  localparam int unsigned NVEC = 5;
  // fields: tx byte, loopback, miso level, expected rx byte
  localparam logic [17:0] VECS [NVEC] = '{
    {8'hA5, 1'b1, 1'b0, 8'hA5},
    {8'h3C, 1'b0, 1'b1, 8'hFF},
    {8'h81, 1'b0, 1'b0, 8'h00},
    {8'h5A, 1'b1, 1'b0, 8'h5A},
    {8'h0F, 1'b1, 1'b1, 8'h0F}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, cfg_wr = 0, cfg_master = 0, data_wr = 0, data_rd = 0;
  logic [7:0] reg_wdata = 0, data_wdata = 0, reg_rdata, rx_data;
  logic master, irq, sck_in = 0, sck_out, sck_oe, mosi_in = 0, mosi_out, mosi_oe;
  logic miso_in, miso_out, miso_oe, ss_n_in = 1, ss_n_out, ss_n_oe;
  logic loop_en = 0, miso_lvl = 0;
  logic [7:0] mosi_mon = 0, miso_cap = 0;
  int n_chk = 0, n_fail = 0;
  bit reported = 0;

  always #2.5 clk = ~clk;
  assign miso_in = loop_en ? mosi_out : miso_lvl;
  always @(posedge sck_out) mosi_mon <= {mosi_mon[6:0], mosi_out};

  spi_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .cfg_wr_i(cfg_wr), .cfg_master_i(cfg_master),
    .master_o(master), .data_wr_i(data_wr), .data_wdata_i(data_wdata),
    .data_rd_i(data_rd), .rx_data_o(rx_data), .irq_o(irq),
    .sck_i(sck_in), .sck_o(sck_out), .sck_oe_o(sck_oe),
    .mosi_i(mosi_in), .mosi_o(mosi_out), .mosi_oe_o(mosi_oe),
    .miso_i(miso_in), .miso_o(miso_out), .miso_oe_o(miso_oe),
    .ss_n_i(ss_n_in), .ss_n_o(ss_n_out), .ss_n_oe_o(ss_n_oe)
  );

  task automatic chk(input string id, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", id, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] v);
    @(negedge clk); reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic wr_cfg(input logic m);
    @(negedge clk); cfg_wr = 1; cfg_master = m;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic wr_data(input logic [7:0] v);
    @(negedge clk); data_wr = 1; data_wdata = v;
    @(negedge clk); data_wr = 0;
  endtask

  task automatic rd_data();
    @(negedge clk); data_rd = 1;
    @(negedge clk); data_rd = 0;
  endtask

  task automatic wait_done(input string id);
    int k = 0;
    while (!reg_rdata[7] && k < 400) begin
      @(negedge clk); k++;
    end
    chk(id, {7'd0, reg_rdata[7]}, 8'd1);
  endtask

  task automatic slave_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); mosi_in = b[i];
      cyc(HALF);
      miso_cap = {miso_cap[6:0], miso_out};
      sck_in = 1;
      cyc(HALF);
      sck_in = 0;
    end
    cyc(HALF + 2);
  endtask

  initial begin
    cyc(200000);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
    report();
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(2);
    // R1 reset state
    chk("R1 reg", reg_rdata, 8'h06);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 master", {7'd0, master}, 8'h00);
    chk("R1 rx", rx_data, 8'h00);
    chk("R8 oe reset", {7'd0, ss_n_oe}, 8'h00);

    // R11 disabled: byte waits in buffer
    wr_data(8'h77);
    chk("R3 txe low", reg_rdata, 8'h04);
    cyc(40);
    chk("R11 held", reg_rdata, 8'h04);
    chk("R11 sck", {7'd0, sck_out}, 8'h00);
    loop_en = 1;
    wr_cfg(1);
    wr_reg(8'h05);
    chk("R3 before load", reg_rdata, 8'h05);
    cyc(1);
    chk("R3 after load", reg_rdata, 8'h07);
    wait_done("R2 done");
    chk("R2 rx loop", rx_data, 8'h77);
    chk("R12 irq set", {7'd0, irq}, 8'h01);
    wr_reg(8'h05);
    rd_data();
    chk("R12 irq clear", {7'd0, irq}, 8'h00);

    // R2 master vector table
    for (int v = 0; v < NVEC; v++) begin
      loop_en  = VECS[v][9];
      miso_lvl = VECS[v][8];
      wr_data(VECS[v][17:10]);
      wait_done("R2 table done");
      chk("R2 table rx", rx_data, VECS[v][7:0]);
      chk("R2 table mosi order", mosi_mon, VECS[v][17:10]);
      chk("R12 table irq", {7'd0, irq}, 8'h01);
      wr_reg(8'h05);
      rd_data();
    end
    loop_en = 1;

    // R4 collision during transfer
    wr_data(8'hC3);
    cyc(4);
    wr_data(8'h99);
    chk("R4 wcol", {7'd0, reg_rdata[6]}, 8'h01);
    chk("R4 txe stays", {7'd0, reg_rdata[1]}, 8'h01);
    wait_done("R4 done");
    chk("R4 rx orig", rx_data, 8'hC3);
    chk("R4 flags", reg_rdata, 8'hC7);
    // R10 write 0 clears, write 1 keeps
    wr_reg(8'h45);
    chk("R10 partial clear", reg_rdata, 8'h47);
    wr_reg(8'h05);
    chk("R10 full clear", reg_rdata, 8'h07);
    rd_data();
    cyc(80);
    chk("R4 no extra xfer", reg_rdata, 8'h07);

    // R8 select output modes
    wr_reg(8'h0D);
    chk("R8 mode11 oe", {7'd0, ss_n_oe}, 8'h01);
    chk("R8 mode11 lvl", {7'd0, ss_n_out}, 8'h01);
    wr_reg(8'h09);
    chk("R8 mode10 lvl", {7'd0, ss_n_out}, 8'h00);
    wr_reg(8'h05);
    chk("R8 mode01 oe", {7'd0, ss_n_oe}, 8'h00);

    // R5 mode fault
    ss_n_in = 0;
    cyc(5);
    chk("R5 fault reg", reg_rdata, 8'h27);
    chk("R5 master off", {7'd0, master}, 8'h00);
    chk("R12 fault irq", {7'd0, irq}, 8'h01);
    ss_n_in = 1;
    wr_reg(8'h05);
    wr_cfg(1);
    wr_reg(8'h01);
    ss_n_in = 0;
    cyc(6);
    chk("R5 mode00 no fault", reg_rdata, 8'h03);
    chk("R5 mode00 master", {7'd0, master}, 8'h01);
    ss_n_in = 1;

    // R6 slave transfer
    wr_cfg(0);
    wr_reg(8'h05);
    wr_data(8'h96);
    cyc(2);
    ss_n_in = 0;
    cyc(4);
    chk("R9 sel oe", {7'd0, miso_oe}, 8'h01);
    slave_byte(8'h3A);
    chk("R6 rx", rx_data, 8'h3A);
    chk("R6 miso", miso_cap, 8'h96);
    chk("R6 done", {7'd0, reg_rdata[7]}, 8'h01);
    // R7 overrun keeps old byte
    slave_byte(8'h11);
    chk("R7 overrun reg", reg_rdata, 8'h97);
    chk("R7 rx kept", rx_data, 8'h3A);
    wr_reg(8'h05);
    rd_data();
    slave_byte(8'h22);
    chk("R7 no overrun rx", rx_data, 8'h22);
    chk("R7 no overrun reg", reg_rdata, 8'h87);

    // R9 deselected slave ignores clock
    wr_reg(8'h05);
    rd_data();
    ss_n_in = 1;
    cyc(4);
    chk("R9 deselect oe", {7'd0, miso_oe}, 8'h00);
    slave_byte(8'h44);
    chk("R9 ignored reg", reg_rdata, 8'h07);
    chk("R9 ignored rx", rx_data, 8'h22);
    wr_reg(8'h01);
    slave_byte(8'h55);
    chk("R9 mode00 rx", rx_data, 8'h55);
    chk("R9 mode00 done", {7'd0, reg_rdata[7]}, 8'h01);

    report();
  end
endmodule